// File: doc/BRIEF.md
# Serial FPGA Configuration Sequencer

This block loads a bitstream into an FPGA through its slave-serial configuration port. It drives the active-low program line, the configuration clock and the serial data line. It watches the FPGA's init and done status lines. A start pulse begins the reset handshake. The block pulls program low, waits for init to fall, releases program, and waits for init to rise again.

After the handshake, the block accepts configuration bits one at a time over a valid/ready interface, in the order the FPGA must receive them. When a byte-wide source sends its most significant bit first, the bytes go out MSB first. The bit marked last ends the data. The block then clocks a fixed run of padding ones and waits for done.

Each of the three waits has its own timeout, counted in clock cycles, and its own error code. The busy, success and error outputs keep their values until the next start. The status inputs pass through two-flop synchronizers.

Top module: `fpga_cfg_seq`

## Requirements
- R1: After reset, prog_no, cclk_o and din_o are high, bit_ready_o is low, busy_o and ok_o are low, and err_o is 0.
- R2: A start_i pulse while not busy sets busy_o on the next clock edge. On the same edge prog_no goes low, ok_o and err_o clear, and cclk_o and din_o stay high.
- R3: If the synchronized init input does not go low within TMO_CYC cycles of program going low, the block ends with err_o = 1 (init-low timeout), releases prog_no high and drops busy_o.
- R4: Once init is seen low, prog_no returns high while busy_o stays high. If init does not then go high within TMO_CYC cycles, the block ends with err_o = 2 (init-high timeout).
- R5: Each bit is clocked as follows. cclk_o goes low with din_o set to the bit for HALF_DIV cycles. cclk_o then rises with din_o unchanged. While cclk_o stays high, din_o returns high after the first high cycle.
- R6: bit_ready_o is high only during the data phase, while the bit clock is idle. Each bit accepted with bit_valid_i high appears on din_o in order of acceptance, with exactly one cclk_o rise per bit.
- R7: After the bit marked by bit_last_i, exactly TRAIL_BITS one bits are clocked, and bit_ready_o stays low.
- R8: After the padding, done going high ends the run with ok_o = 1 and err_o = 0. If done does not rise within TMO_CYC cycles, the run ends with err_o = 3 (done timeout) and ok_o = 0.
- R9: busy_o, ok_o and err_o hold their values until the next start. A start_i pulse while busy has no effect on the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; acted on only while idle |
| bit_valid_i | input | 1 | Configuration bit available |
| bit_data_i | input | 1 | Configuration bit value |
| bit_last_i | input | 1 | Marks the final configuration bit |
| bit_ready_o | output | 1 | Block takes the offered bit on this edge |
| prog_no | output | 1 | Program line to the FPGA, active low |
| cclk_o | output | 1 | Configuration clock to the FPGA |
| din_o | output | 1 | Serial configuration data to the FPGA |
| init_i | input | 1 | Init status line from the FPGA (asynchronous) |
| done_i | input | 1 | Done status line from the FPGA (asynchronous) |
| busy_o | output | 1 | Sequence in progress |
| ok_o | output | 1 | Last run finished successfully |
| err_o | output | 2 | 0 none, 1 init-low timeout, 2 init-high timeout, 3 done timeout |

## Verification
A start is visible on prog_no and busy_o one edge after it is taken. A change on init or done reaches the sequencer two edges later through the synchronizer, and its effect on the outputs appears one edge after that. Each bit uses one idle cycle, HALF_DIV low cycles and HALF_DIV high cycles. A timeout fires TMO_CYC cycles after its wait begins. The bench drives and samples on the falling clock edge, so every register has settled. It polls for busy_o to fall within a bounded number of cycles before it checks the result codes, and it checks that no result appears too early at a point well inside each timeout window.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_PRG, S_INIT, S_DATA, S_TRAIL, S_DONE
  } seq_st_e;

  typedef enum logic [1:0] {
    E_NONE    = 2'd0,
    E_INIT_LO = 2'd1,
    E_INIT_HI = 2'd2,
    E_DONE    = 2'd3
  } err_e;

  typedef enum logic [1:0] {B_IDLE, B_LO, B_HI} bit_st_e;
endpackage

// File: rtl/fcs_sync.sv
module fcs_sync #(
  parameter int          W       = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [1:0] ff_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff_q <= {2{RST_VAL[g]}};
      else         ff_q <= {ff_q[0], d_i[g]};
    end
    assign q_o[g] = ff_q[1];
  end
endmodule

// File: rtl/fcs_timer.sv
module fcs_timer #(
  parameter int CYC = 375000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  output logic expired_o
);
  localparam int CNT_W = $clog2(CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (restart_i || !run_i) cnt_q <= '0;
    else if (cnt_q != LAST)      cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = run_i && (cnt_q == LAST);

  assert_cnt_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  assert_idle_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/fcs_bitclk.sv
module fcs_bitclk
  import fcs_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  input  logic bit_i,
  output logic idle_o,
  output logic cclk_o,
  output logic din_o
);
  localparam int PH_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(HALF_DIV - 1);

  bit_st_e         st_q;
  logic [PH_W-1:0] ph_q;
  logic            cclk_q, din_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= B_IDLE;
      ph_q   <= '0;
      cclk_q <= 1'b1;
      din_q  <= 1'b1;
    end else begin
      unique case (st_q)
        B_IDLE: if (go_i) begin
          cclk_q <= 1'b0;
          din_q  <= bit_i;
          ph_q   <= '0;
          st_q   <= B_LO;
        end
        B_LO: if (ph_q == PH_LAST) begin
          cclk_q <= 1'b1;
          ph_q   <= '0;
          st_q   <= B_HI;
        end else begin
          ph_q <= ph_q + 1'b1;
        end
        B_HI: begin
          din_q <= 1'b1;  // data returns high once the rising edge is past
          if (ph_q == PH_LAST) st_q <= B_IDLE;
          else                 ph_q <= ph_q + 1'b1;
        end
        default: st_q <= B_IDLE;
      endcase
    end
  end

  assign idle_o = (st_q == B_IDLE);
  assign cclk_o = cclk_q;
  assign din_o  = din_q;

  assert_din_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cclk_q) |-> (din_q == $past(din_q)));
  assert_din_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cclk_q && $past(cclk_q)) |-> din_q);
  assert_cclk_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cclk_q |-> (st_q == B_LO));
endmodule

// File: rtl/fpga_cfg_seq.sv
module fpga_cfg_seq
  import fcs_pkg::*;
#(
  parameter int TMO_CYC    = 375000,
  parameter int HALF_DIV   = 2,
  parameter int TRAIL_BITS = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       bit_valid_i,
  input  logic       bit_data_i,
  input  logic       bit_last_i,
  output logic       bit_ready_o,
  output logic       prog_no,
  output logic       cclk_o,
  output logic       din_o,
  input  logic       init_i,
  input  logic       done_i,
  output logic       busy_o,
  output logic       ok_o,
  output logic [1:0] err_o
);
  localparam int TR_W = $clog2(TRAIL_BITS + 1);
  localparam logic [TR_W-1:0] TR_END = TR_W'(TRAIL_BITS);

  seq_st_e         st_q, st_d;
  err_e            err_q, err_d;
  logic            ok_q, ok_d;
  logic            prog_q;
  logic [TR_W-1:0] tr_q, tr_d;
  logic            init_s, done_s;
  logic            eng_idle, eng_go, eng_bit;
  logic            tmo_run, tmo_exp;

  fcs_sync #(.W(2), .RST_VAL(2'b01)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({done_i, init_i}),
    .q_o   ({done_s, init_s})
  );

  assign tmo_run = (st_q == S_PRG) || (st_q == S_INIT) || (st_q == S_DONE);

  fcs_timer #(.CYC(TMO_CYC)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (tmo_run),
    .restart_i(st_d != st_q),
    .expired_o(tmo_exp)
  );

  fcs_bitclk #(.HALF_DIV(HALF_DIV)) u_bitclk (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .go_i  (eng_go),
    .bit_i (eng_bit),
    .idle_o(eng_idle),
    .cclk_o(cclk_o),
    .din_o (din_o)
  );

  assign bit_ready_o = (st_q == S_DATA) && eng_idle;

  always_comb begin
    st_d    = st_q;
    err_d   = err_q;
    ok_d    = ok_q;
    tr_d    = tr_q;
    eng_go  = 1'b0;
    eng_bit = 1'b1;
    unique case (st_q)
      S_IDLE: if (start_i) begin
        st_d  = S_PRG;
        err_d = E_NONE;
        ok_d  = 1'b0;
      end
      S_PRG: begin
        if (!init_s)      st_d = S_INIT;
        else if (tmo_exp) begin
          st_d  = S_IDLE;
          err_d = E_INIT_LO;
        end
      end
      S_INIT: begin
        if (init_s)       st_d = S_DATA;
        else if (tmo_exp) begin
          st_d  = S_IDLE;
          err_d = E_INIT_HI;
        end
      end
      S_DATA: if (bit_valid_i && bit_ready_o) begin
        eng_go  = 1'b1;
        eng_bit = bit_data_i;
        if (bit_last_i) begin
          st_d = S_TRAIL;
          tr_d = '0;
        end
      end
      S_TRAIL: if (eng_idle) begin
        if (tr_q == TR_END) st_d = S_DONE;
        else begin
          eng_go = 1'b1;
          tr_d   = tr_q + 1'b1;
        end
      end
      S_DONE: begin
        if (done_s) begin
          st_d = S_IDLE;
          ok_d = 1'b1;
        end else if (tmo_exp) begin
          st_d  = S_IDLE;
          err_d = E_DONE;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      err_q  <= E_NONE;
      ok_q   <= 1'b0;
      tr_q   <= '0;
      prog_q <= 1'b1;
    end else begin
      st_q   <= st_d;
      err_q  <= err_d;
      ok_q   <= ok_d;
      tr_q   <= tr_d;
      prog_q <= (st_d != S_PRG);
    end
  end

  assign prog_no = prog_q;
  assign busy_o  = (st_q != S_IDLE);
  assign ok_o    = ok_q;
  assign err_o   = err_q;

  assert_prog_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prog_no |-> busy_o);
  assert_start_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (busy_o && !prog_no && !ok_o && (err_o == 2'd0)));
  assert_end_release_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> prog_no);
  assert_ready_phase_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_ready_o |-> (busy_o && prog_no && cclk_o));
  assert_result_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ok_o && (err_o != 2'd0)));
  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(ok_o) && $stable(err_o)));
  assert_trail_noready_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_TRAIL) |-> !bit_ready_o);
endmodule

// File: tb/fpga_cfg_seq_tb.sv
module fpga_cfg_seq_tb;
  localparam int TMO  = 200;
  localparam int HALF = 2;
  localparam int TRL  = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, bv = 1'b0, bd = 1'b0, bl = 1'b0;
  logic init_l = 1'b1, done_l = 1'b0;
  logic rdy, prog_n, cclk, din, busy, ok;
  logic [1:0] err;

  always #4 clk = ~clk;  // 125 MHz

  fpga_cfg_seq #(.TMO_CYC(TMO), .HALF_DIV(HALF), .TRAIL_BITS(TRL)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .bit_valid_i(bv),
    .bit_data_i(bd), .bit_last_i(bl), .bit_ready_o(rdy), .prog_no(prog_n),
    .cclk_o(cclk), .din_o(din), .init_i(init_l), .done_i(done_l),
    .busy_o(busy), .ok_o(ok), .err_o(err)
  );

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  // FPGA model controls and observations
  bit m_pull = 1'b0, m_rel = 1'b0, m_done = 1'b0;
  int exp_total = 0, cap_cnt = 0, rel_cnt = 0, wave_bad = 0, rdy_bad = 0;
  bit after_last = 1'b0;
  logic cap [0:255];
  logic prev_cclk = 1'b1, prev_din = 1'b1;

  always @(negedge clk) begin
    prev_cclk <= cclk;
    prev_din  <= din;
    if (rst_n && !prog_n) begin
      if (m_pull) init_l <= 1'b0;
      done_l  <= 1'b0;
      cap_cnt <= 0;
      rel_cnt <= 0;
    end else if (rst_n && !init_l && m_rel) begin
      if (rel_cnt == 5) init_l <= 1'b1;
      else              rel_cnt <= rel_cnt + 1;
    end
    if (rst_n && prog_n && init_l && busy) begin
      if (!prev_cclk && cclk) begin
        cap[cap_cnt[7:0]] <= din;
        cap_cnt <= cap_cnt + 1;
        if (din != prev_din) wave_bad <= wave_bad + 1;
      end
      if (prev_cclk && cclk && !din) wave_bad <= wave_bad + 1;
    end
    if (m_done && prog_n && cap_cnt == exp_total) done_l <= 1'b1;
    if (after_last && rdy) rdy_bad <= rdy_bad + 1;
  end

  task automatic chk(input bit cond, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_idle(input int lim);
    for (int i = 0; i < lim && busy; i++) @(negedge clk);
  endtask

  task automatic send_bit(input logic b, input logic last);
    bv = 1'b1; bd = b; bl = last;
    for (int i = 0; i < 1000; i++) begin
      if (rdy) break;
      @(negedge clk);
    end
    @(negedge clk);
    bv = 1'b0; bl = 1'b0;
    if (last) after_last = 1'b1;
  endtask

  task automatic t_reset();
    chk(prog_n && cclk && din, "R1", "pins high", {prog_n, cclk, din}, 7);
    chk(!busy && !ok && !rdy, "R1", "busy/ok/ready", {busy, ok, rdy}, 0);
    chk(err == 2'd0, "R1", "err", err, 0);
  endtask

  task automatic t_init_lo_timeout();
    m_pull = 1'b0; m_rel = 1'b0; m_done = 1'b0;
    do_start();
    chk(!prog_n && busy && cclk && din, "R2", "start drive",
        {prog_n, busy, cclk, din}, 7);
    repeat (TMO / 2) @(negedge clk);
    chk(busy && err == 2'd0, "R3", "early result", err, 0);
    wait_idle(4 * TMO);
    chk(err == 2'd1 && !ok, "R3", "init-low err", err, 1);
    chk(prog_n && !busy, "R3", "prog released", prog_n, 1);
  endtask

  task automatic t_init_hi_timeout();
    m_pull = 1'b1; m_rel = 1'b0; m_done = 1'b0;
    do_start();
    chk(err == 2'd0 && busy, "R2", "err cleared at start", err, 0);
    for (int i = 0; i < 100 && !prog_n; i++) @(negedge clk);
    chk(prog_n && busy, "R4", "prog released while busy", {prog_n, busy}, 3);
    wait_idle(4 * TMO);
    chk(err == 2'd2 && !ok && !busy, "R4", "init-high err", err, 2);
  endtask

  task automatic t_load(input bit with_done, input int nbytes);
    logic [7:0] pat [0:2];
    int idx;
    pat[0] = 8'hA5; pat[1] = 8'h3C; pat[2] = 8'h0F;
    m_pull = 1'b1; m_rel = 1'b1; m_done = with_done;
    exp_total = nbytes * 8 + TRL;
    wave_bad = 0; rdy_bad = 0; after_last = 1'b0;
    do_start();
    chk(!ok && err == 2'd0, "R2", "results cleared", err, 0);
    idx = 0;
    for (int by = 0; by < nbytes; by++)
      for (int bi = 7; bi >= 0; bi--) begin
        send_bit(pat[by][bi], (by == nbytes - 1) && (bi == 0));
        idx++;
        if (idx == 10) begin  // R9: start while busy must not disturb the run
          start = 1'b1; @(negedge clk); start = 1'b0;
        end
      end
    wait_idle(8 * TMO + 2000);
    after_last = 1'b0;
    chk(cap_cnt == exp_total, "R7", "cclk rises", cap_cnt, exp_total);
    idx = 0;
    for (int by = 0; by < nbytes; by++)
      for (int bi = 7; bi >= 0; bi--) begin
        chk(cap[idx] == pat[by][bi], "R6", "data bit order", cap[idx], pat[by][bi]);
        idx++;
      end
    for (int k = idx; k < exp_total; k++)
      if (cap[k] !== 1'b1) chk(1'b0, "R7", "pad bit", cap[k], 1);
    chk(1'b1, "R7", "pad bits", 1, 1);
    chk(wave_bad == 0, "R5", "bit waveform", wave_bad, 0);
    chk(rdy_bad == 0, "R7", "ready after last", rdy_bad, 0);
    if (with_done)
      chk(ok && err == 2'd0 && !busy, "R8", "success", {ok, err}, 4);
    else
      chk(!ok && err == 2'd3 && !busy, "R8", "done timeout", err, 3);
  endtask

  task automatic t_hold();
    logic ok0; logic [1:0] e0;
    ok0 = ok; e0 = err;
    bv = 1'b1; bd = 1'b0;
    repeat (40) @(negedge clk);
    bv = 1'b0;
    chk(ok == ok0 && err == e0 && !busy, "R9", "results held", {ok, err}, {ok0, e0});
    chk(prog_n && cclk && din && !rdy, "R9", "pins idle", {prog_n, cclk, din, rdy}, 14);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_init_lo_timeout();
    t_init_hi_timeout();
    t_load(1'b1, 3);
    t_hold();
    t_load(1'b0, 1);
    t_hold();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule